// File: doc/BRIEF.md
# Burst Write Traffic Generator

This block drives a stream of burst writes onto a memory-mapped bus. Software sets the start address, the number of bursts, the beats per burst and the run mode through a small 64-bit register port, then sets the enable bit. The generator issues bursts back to back. Each burst advances the address by the number of bytes the previous burst wrote. The write data is a running 32-bit beat index, and every byte lane is enabled.

In fixed mode the run ends after the programmed number of bursts, and the generator clears its own enable bit so that software can see the run is over. In non-stop mode bursts continue until software clears enable. Clearing enable never cuts a burst short. A clear-on-read register reports how many bursts have completed since it was last read. The error-count location is reserved and always reads zero.

Top module: `burst_write_gen`

## Requirements
- R1: After reset, m_write is low and reads of offsets 0x20, 0x28, 0x30 and 0x38 all return zero.
- R2: A read pulse on reg_rd places data on reg_rdata in the following cycle. Offset 0x20 holds the start address in bits [31:0]. Offset 0x38 holds enable in bit 31 and the burst length in bits [7:0]. Readback of both offsets returns the written fields, and all other bits read as zero.
- R3: A beat is taken when m_write is high and m_waitreq is low. While m_waitreq is high, m_write, m_addr, m_burstcount and m_wdata hold their values. m_burstcount equals the programmed burst length for every beat of a burst.
- R4: Burst k of a run (k from 0) uses address base + k * length * 4, modulo 2^32. The address is held for every beat of that burst.
- R5: m_wdata is 0 on the first beat of a run and rises by one on each accepted beat, across burst boundaries. m_byteen is all ones whenever m_write is high.
- R6: With offset 0x28 bit 31 = 0 (fixed mode), exactly N = bits [11:0] bursts are written, and then bit 31 of offset 0x38 clears by itself. With N = 0, no beat is written and enable clears.
- R7: With offset 0x28 bit 31 = 1 (non-stop mode), bursts continue past the programmed count for as long as enable stays set.
- R8: Clearing enable during a burst lets that burst complete all of its beats. After that, no further beat is issued.
- R9: A read of offset 0x28 returns the mode in bit 31 and, in bits [11:0], the number of bursts completed since the previous read of that offset. The read clears the count.
- R10: Offset 0x30 reads zero at all times. Writes to it change nothing.
- R11: While the burst length is 0, no write is issued, even with enable set, and the enable bit stays set.
- R12: Each new run starts again at the programmed start address with data value 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 64 | Register write data |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 64 | Register read data, valid the cycle after reg_rd |
| m_addr | output | 32 | Burst start byte address |
| m_burstcount | output | 8 | Beats in the current burst |
| m_write | output | 1 | Write request |
| m_wdata | output | 32 | Write data (beat index) |
| m_byteen | output | 4 | Byte enables |
| m_waitreq | input | 1 | Target stall; the beat is held while high |

## Verification
The failure that matters most is a wrong beat counter or remaining-burst counter. It shows up on the bus within one burst: a burst with the wrong length, an address step of the wrong size after the last beat, or a fixed run that stops one burst early or late and so leaves the enable bit set at the wrong time. A corrupted data counter shows up on the very next accepted beat as a break in the data sequence. A completion counter that misses a clear shows up at the next read of offset 0x28. Random stalls on m_waitreq make the hold-under-stall behaviour visible on any beat.

// File: rtl/bwg_pkg.sv
package bwg_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_ARM  = 2'd1,
    SQ_BEAT = 2'd2
  } sq_state_e;

  localparam int OFS_BASE  = 8'h20;
  localparam int OFS_COUNT = 8'h28;
  localparam int OFS_ERR   = 8'h30;
  localparam int OFS_CTRL  = 8'h38;

  localparam int FLAG_BIT  = 31;

endpackage

// File: rtl/bwg_regs.sv
module bwg_regs
  import bwg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 12,
  parameter int LEN_W  = 8,
  parameter int RA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic              reg_wr,
  input  logic [63:0]       reg_wdata,
  input  logic              reg_rd,
  output logic [63:0]       reg_rdata,
  input  logic              xfer_done,
  input  logic              seq_done,
  output logic [ADDR_W-1:0] base_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              mode_q,
  output logic              en_q,
  output logic [LEN_W-1:0]  len_q
);

  logic              hit_base, hit_count, hit_ctrl;
  logic [ADDR_W-1:0] base_d;
  logic [CNT_W-1:0]  cnt_d;
  logic              mode_d, en_d;
  logic [LEN_W-1:0]  len_d;
  logic [CNT_W-1:0]  xc_q, xc_d;
  logic [63:0]       rd_mux, rdata_q;
  logic              unused_hi;

  assign unused_hi = ^reg_wdata[63:32];

  assign hit_base  = (reg_addr == RA_W'(OFS_BASE));
  assign hit_count = (reg_addr == RA_W'(OFS_COUNT));
  assign hit_ctrl  = (reg_addr == RA_W'(OFS_CTRL));

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    mode_d = mode_q;
    en_d   = en_q;
    len_d  = len_q;
    if (reg_wr && hit_base) base_d = reg_wdata[ADDR_W-1:0];
    if (reg_wr && hit_count) begin
      cnt_d  = reg_wdata[CNT_W-1:0];
      mode_d = reg_wdata[FLAG_BIT];
    end
    if (reg_wr && hit_ctrl) begin
      en_d  = reg_wdata[FLAG_BIT];
      len_d = reg_wdata[LEN_W-1:0];
    end else if (seq_done) begin
      en_d = 1'b0;
    end
  end

  always_comb begin
    xc_d = xc_q;
    if (reg_rd && hit_count) xc_d = '0;
    if (xfer_done)           xc_d = xc_d + CNT_W'(1);
  end

  always_comb begin
    rd_mux = '0;
    if (hit_base) begin
      rd_mux[ADDR_W-1:0] = base_q;
    end else if (hit_count) begin
      rd_mux[FLAG_BIT]   = mode_q;
      rd_mux[CNT_W-1:0]  = xc_q;
    end else if (hit_ctrl) begin
      rd_mux[FLAG_BIT]   = en_q;
      rd_mux[LEN_W-1:0]  = len_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      cnt_q   <= '0;
      mode_q  <= 1'b0;
      en_q    <= 1'b0;
      len_q   <= '0;
      xc_q    <= '0;
      rdata_q <= '0;
    end else begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
      mode_q <= mode_d;
      en_q   <= en_d;
      len_q  <= len_d;
      xc_q   <= xc_d;
      if (reg_rd) rdata_q <= rd_mux;
    end
  end

  assign reg_rdata = rdata_q;

  assert_err_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == RA_W'(OFS_ERR)) |=> (reg_rdata == 64'd0));

  assert_self_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done && !(reg_wr && hit_ctrl)) |=> !en_q);

  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && hit_count && !xfer_done) |=> (xc_q == '0));

endmodule

// File: rtl/bwg_pattern.sv
module bwg_pattern #(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                step,
  output logic [DATA_W-1:0]   word,
  output logic [DATA_W/8-1:0] byteen
);

  localparam int LANES = DATA_W / 32;

  logic [31:0] idx_q, idx_d;

  always_comb begin
    idx_d = idx_q;
    if (load)      idx_d = '0;
    else if (step) idx_d = idx_q + 32'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign word[32*g +: 32] = idx_q;
  end

  assign byteen = '1;

  assert_pattern_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (word[31:0] == $past(word[31:0]) + 32'd1));

endmodule

// File: rtl/bwg_seq.sv
module bwg_seq
  import bwg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 12,
  parameter int LEN_W  = 8,
  parameter int BYTES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              mode,
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [LEN_W-1:0]  len,
  input  logic              m_waitreq,
  output logic [ADDR_W-1:0] m_addr,
  output logic [LEN_W-1:0]  m_burstcount,
  output logic              m_write,
  output logic              beat_acc,
  output logic              run_load,
  output logic              xfer_done,
  output logic              seq_done
);

  localparam int SH = $clog2(BYTES);

  sq_state_e         st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d, stride;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic [LEN_W-1:0]  blen_q, blen_d, left_q, left_d;

  assign stride   = ADDR_W'(blen_q) << SH;
  assign beat_acc = (st_q == SQ_BEAT) && !m_waitreq;

  always_comb begin
    st_d      = st_q;
    addr_d    = addr_q;
    rem_d     = rem_q;
    blen_d    = blen_q;
    left_d    = left_q;
    run_load  = 1'b0;
    xfer_done = 1'b0;
    seq_done  = 1'b0;
    case (st_q)
      SQ_IDLE: begin
        if (en && len != '0) begin
          st_d     = SQ_ARM;
          addr_d   = base;
          rem_d    = cnt;
          run_load = 1'b1;
        end
      end
      SQ_ARM: begin
        if (!en) begin
          st_d = SQ_IDLE;
        end else if (!mode && rem_q == '0) begin
          seq_done = 1'b1;
          st_d     = SQ_IDLE;
        end else if (len != '0) begin
          blen_d = len;
          left_d = len;
          st_d   = SQ_BEAT;
        end
      end
      SQ_BEAT: begin
        if (beat_acc) begin
          left_d = left_q - LEN_W'(1);
          if (left_q == LEN_W'(1)) begin
            xfer_done = 1'b1;
            addr_d    = addr_q + stride;
            if (!mode) rem_d = rem_q - CNT_W'(1);
            st_d      = SQ_ARM;
          end
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      addr_q <= '0;
      rem_q  <= '0;
      blen_q <= '0;
      left_q <= '0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      rem_q  <= rem_d;
      blen_q <= blen_d;
      left_q <= left_d;
    end
  end

  assign m_write      = (st_q == SQ_BEAT);
  assign m_addr       = addr_q;
  assign m_burstcount = blen_q;

  assert_hold_under_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_write && m_waitreq) |=> (m_write && $stable(m_addr) && $stable(m_burstcount)));

  assert_len_nonzero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    m_write |-> (m_burstcount != '0));

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> (m_addr == $past(m_addr) + (ADDR_W'($past(m_burstcount)) << SH)));

  assert_stop_after_burst_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !m_write) |=> !m_write);

endmodule

// File: rtl/burst_write_gen.sv
module burst_write_gen #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 12,
  parameter int LEN_W  = 8,
  parameter int RA_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [RA_W-1:0]     reg_addr,
  input  logic                reg_wr,
  input  logic [63:0]         reg_wdata,
  input  logic                reg_rd,
  output logic [63:0]         reg_rdata,
  output logic [ADDR_W-1:0]   m_addr,
  output logic [LEN_W-1:0]    m_burstcount,
  output logic                m_write,
  output logic [DATA_W-1:0]   m_wdata,
  output logic [DATA_W/8-1:0] m_byteen,
  input  logic                m_waitreq
);

  localparam int BYTES = DATA_W / 8;

  logic              rst_s0, rst_s1;
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              mode_q, en_q;
  logic [LEN_W-1:0]  len_q;
  logic              beat_acc, run_load, xfer_done, seq_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0 <= 1'b0;
      rst_s1 <= 1'b0;
    end else begin
      rst_s0 <= 1'b1;
      rst_s1 <= rst_s0;
    end
  end

  bwg_regs #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LEN_W(LEN_W), .RA_W(RA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_s1),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .xfer_done(xfer_done), .seq_done(seq_done),
    .base_q(base_q), .cnt_q(cnt_q), .mode_q(mode_q), .en_q(en_q), .len_q(len_q)
  );

  bwg_seq #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LEN_W(LEN_W), .BYTES(BYTES)
  ) u_seq (
    .clk(clk), .rst_n(rst_s1),
    .en(en_q), .mode(mode_q), .base(base_q), .cnt(cnt_q), .len(len_q),
    .m_waitreq(m_waitreq),
    .m_addr(m_addr), .m_burstcount(m_burstcount), .m_write(m_write),
    .beat_acc(beat_acc), .run_load(run_load),
    .xfer_done(xfer_done), .seq_done(seq_done)
  );

  bwg_pattern #(
    .DATA_W(DATA_W)
  ) u_pat (
    .clk(clk), .rst_n(rst_s1),
    .load(run_load), .step(beat_acc),
    .word(m_wdata), .byteen(m_byteen)
  );

endmodule

// File: tb/sim_burst_write_gen.sv
module sim_burst_write_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [63:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [63:0] reg_rdata;
  logic [31:0] m_addr;
  logic [7:0]  m_burstcount;
  logic        m_write;
  logic [31:0] m_wdata;
  logic [3:0]  m_byteen;
  logic        m_waitreq = 1'b0;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit stall_en = 1'b0;
  bit finished = 1'b0;

  logic [7:0]  lfsr = 8'hA5;
  int          beat_cnt = 0;
  int          hold_err = 0;
  logic [31:0] b_addr [512];
  logic [31:0] b_data [512];
  logic [7:0]  b_bc   [512];
  logic [3:0]  b_be   [512];
  logic        held_v = 1'b0;
  logic [31:0] held_a, held_d;
  logic [7:0]  held_c;

  always #5 clk = ~clk;

  burst_write_gen u0 (
    .clk(clk), .rst_n(rst_n),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .m_addr(m_addr), .m_burstcount(m_burstcount), .m_write(m_write),
    .m_wdata(m_wdata), .m_byteen(m_byteen), .m_waitreq(m_waitreq)
  );

  // bus monitor: outputs are settled since the last rising edge
  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    m_waitreq = stall_en & lfsr[0] & ~lfsr[2];
    if (held_v) begin
      if (!m_write || m_addr !== held_a || m_wdata !== held_d || m_burstcount !== held_c)
        hold_err = hold_err + 1;
    end
    held_v = m_write && m_waitreq;
    held_a = m_addr;
    held_d = m_wdata;
    held_c = m_burstcount;
    if (rst_n && m_write && !m_waitreq) begin
      if (beat_cnt < 512) begin
        b_addr[beat_cnt] = m_addr;
        b_data[beat_cnt] = m_wdata;
        b_bc[beat_cnt]   = m_burstcount;
        b_be[beat_cnt]   = m_byteen;
      end
      beat_cnt = beat_cnt + 1;
    end
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 150000 && !finished) begin
      fails = fails + 1;
      $display("FAIL watchdog: run did not end (actual cycle %0d, expected < 150000)", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [63:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_idle(input string req);
    logic [63:0] v;
    int n;
    n = 0;
    v = 64'h8000_0000;
    while (v[31] && n < 5000) begin
      reg_read(8'h38, v);
      n = n + 1;
    end
    check(req, {63'd0, v[31]}, 64'd0);
  endtask

  task automatic t_reset;
    logic [63:0] v;
    check("R1 m_write after reset", {63'd0, m_write}, 64'd0);
    reg_read(8'h20, v); check("R1 base reset", v, 64'd0);
    reg_read(8'h28, v); check("R1 count reset", v, 64'd0);
    reg_read(8'h30, v); check("R1 error reset", v, 64'd0);
    reg_read(8'h38, v); check("R1 control reset", v, 64'd0);
  endtask

  task automatic t_regs;
    logic [63:0] v;
    reg_write(8'h20, 64'hFFFF_FFFF_1234_5678);
    reg_read(8'h20, v); check("R2 base readback", v, 64'h1234_5678);
    reg_write(8'h38, 64'h0000_0000_7FFF_FF05);
    reg_read(8'h38, v); check("R2 control readback", v, 64'h5);
    reg_write(8'h38, 64'h0);
  endtask

  task automatic t_fixed;
    logic [63:0] v;
    int s, bad_a, bad_d, bad_c, bad_e;
    s = beat_cnt;
    stall_en = 1'b1;
    reg_write(8'h20, 64'h100);
    reg_write(8'h28, 64'h3);
    reg_write(8'h38, 64'h8000_0004);
    wait_idle("R6 fixed run enable self-clear");
    stall_en = 1'b0;
    check("R6 fixed run beat total", beat_cnt - s, 12);
    bad_a = 0; bad_d = 0; bad_c = 0; bad_e = 0;
    for (int i = 0; i < 12; i++) begin
      if (b_addr[s+i] !== 32'h100 + 32'((i / 4) * 16)) bad_a++;
      if (b_data[s+i] !== 32'(i)) bad_d++;
      if (b_bc[s+i] !== 8'd4) bad_c++;
      if (b_be[s+i] !== 4'hF) bad_e++;
    end
    check("R4 address per burst", bad_a, 0);
    check("R5 data pattern", bad_d, 0);
    check("R3 burstcount", bad_c, 0);
    check("R5 byte enables", bad_e, 0);
    check("R3 hold under waitreq", hold_err, 0);
    reg_read(8'h28, v); check("R9 completed count", v, 64'h3);
    reg_read(8'h28, v); check("R9 cleared by read", v, 64'h0);
  endtask

  task automatic t_zero_count;
    logic [63:0] v;
    int s;
    s = beat_cnt;
    reg_write(8'h28, 64'h0);
    reg_write(8'h38, 64'h8000_0004);
    repeat (20) @(negedge clk);
    check("R6 zero count no beats", beat_cnt - s, 0);
    reg_read(8'h38, v); check("R6 zero count enable cleared", v, 64'h4);
  endtask

  task automatic t_zero_len;
    logic [63:0] v;
    int s;
    s = beat_cnt;
    reg_write(8'h28, 64'h5);
    reg_write(8'h38, 64'h8000_0000);
    repeat (20) @(negedge clk);
    check("R11 zero length no beats", beat_cnt - s, 0);
    reg_read(8'h38, v); check("R11 enable stays set", v, 64'h8000_0000);
    reg_write(8'h38, 64'h0);
  endtask

  task automatic t_nonstop;
    logic [63:0] v;
    int s, tot, bad_a, bad_d, n;
    s = beat_cnt;
    reg_write(8'h20, 64'hFFFF_FFC0);
    reg_write(8'h28, 64'h8000_0002);
    reg_write(8'h38, 64'h8000_0008);
    n = 0;
    while (beat_cnt - s < 21 && n < 2000) begin
      @(negedge clk);
      n++;
    end
    reg_write(8'h38, 64'h8);
    repeat (30) @(negedge clk);
    tot = beat_cnt - s;
    check("R7 non-stop passes count (>=3 bursts)", {63'd0, tot >= 24}, 64'd1);
    check("R8 last burst completed", tot % 8, 0);
    repeat (20) @(negedge clk);
    check("R8 no beats after stop", beat_cnt - s, tot);
    bad_a = 0; bad_d = 0;
    for (int i = 0; i < tot && i < 200; i++) begin
      if (b_addr[s+i] !== 32'hFFFF_FFC0 + 32'((i / 8) * 32)) bad_a++;
      if (b_data[s+i] !== 32'(i)) bad_d++;
    end
    check("R4 address wrap", bad_a, 0);
    check("R5 data across bursts", bad_d, 0);
    reg_read(8'h28, v); check("R9 count with mode", v, 64'h8000_0000 | 64'(tot / 8));
  endtask

  task automatic t_restart;
    int s;
    s = beat_cnt;
    reg_write(8'h20, 64'h40);
    reg_write(8'h28, 64'h1);
    reg_write(8'h38, 64'h8000_0002);
    wait_idle("R12 restart run ends");
    check("R12 restart beats", beat_cnt - s, 2);
    check("R12 restart address", b_addr[s], 64'h40);
    check("R12 restart data first", b_data[s], 64'h0);
    check("R12 restart data second", b_data[s+1], 64'h1);
  endtask

  task automatic t_err_reg;
    logic [63:0] v;
    reg_write(8'h30, 64'hFFFF_FFFF_FFFF_FFFF);
    reg_read(8'h30, v); check("R10 error reg reads zero", v, 64'h0);
    reg_read(8'h20, v); check("R10 error write leaves base", v, 64'h40);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_regs();
    t_fixed();
    t_zero_count();
    t_zero_len();
    t_nonstop();
    t_restart();
    t_err_reg();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule